// File: doc/BRIEF.md
# Display-Synchronized Watchdog Timer

This block watches a display pipeline for stalls. A 16-bit counter counts down once for each tick taken from a display-timing source: a line or frame pulse, a chosen edge of the horizontal sync, vertical sync or tearing-effect line, or one of four event pulses. A 4-bit source field in the control register picks the source. If the pipeline stops producing the selected timing, the counter reaches zero and the block raises a sticky expiry flag and an interrupt.

Software starts the watchdog and stops it through two separate write-one bits, and reads a status bit to see whether it is running. The counter is refilled from a software-written reload value. Software can force a refill, or hardware can trigger one on a chosen edge of an external reload input, so a healthy pipeline keeps the counter away from zero. Access is through a small word-addressed register port with a read latency of one cycle.

Top module: `disp_wdog`

## Requirements
- R1: After reset the watchdog is stopped, the count reads 0, the expiry flag and `irq_o` are 0, and CTRL reads 0.
- R2: Writing CTRL with bit 0 = 1 starts the watchdog and loads the count from RELOAD (address 1, bits 15:0). Writing bit 0 = 0 has no effect.
- R3: Writing CTRL with bit 1 = 1 stops the watchdog and writing bit 1 = 0 has no effect. If bits 0 and 1 are both 1 in the same write, the watchdog stops.
- R4: CTRL (address 0) reads bit 3 = 1 while the watchdog runs and 0 while it is stopped. It reads back the tick source in bits 7:4 and the reload mode in bits 9:8. Bits 0, 1 and 2 read 0.
- R5: CTRL bits 7:4 choose the tick source: 0 line pulse, 1 frame pulse, 2/3 hsync rise/fall, 4/5 vsync rise/fall, 6/7 te rise/fall, 8 to 11 `evt_i[0]` to `evt_i[3]`. While running, each tick from the chosen source lowers the count (address 2) by one. Other sources have no effect.
- R6: Source codes 12 to 15 produce no ticks.
- R7: A sync edge gives exactly one tick, however long the new level is held.
- R8: Writing CTRL with bit 2 = 1 loads the count from RELOAD. The bit reads back as 0.
- R9: CTRL bits 9:8 set the hardware reload mode: 1 reloads on a rising edge of `rld_i`, 2 on a falling edge, and 0 or 3 never reload.
- R10: When a reload and a tick arrive in the same cycle, the count takes the reload value.
- R11: While the watchdog is stopped, ticks and hardware reloads leave the count unchanged.
- R12: A tick that takes the count from 1 to 0 sets the expiry flag (FLAG, address 3, bit 0) and `irq_o`. At 0 the count stays at 0. Writing FLAG bit 0 = 1 clears the flag and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_i` |
| line_i | input | 1 | Line pulse, one cycle per line |
| frame_i | input | 1 | Frame pulse, one cycle per frame |
| hsync_i | input | 1 | Horizontal sync level |
| vsync_i | input | 1 | Vertical sync level |
| te_i | input | 1 | Tearing-effect level |
| evt_i | input | 4 | Event pulses |
| rld_i | input | 1 | Hardware reload level |
| irq_o | output | 1 | Expiry interrupt |

## Verification
The checks assume that every input is already synchronous to `clk`, and that pulse sources are high for single cycles. They also assume that no CTRL write arrives in the same cycle as a selected tick, because a source change would then be ambiguous. The stimulus drives every input on the falling clock edge. It holds each pulse for exactly one cycle and changes sync levels only between register accesses. It leaves several idle cycles after each event so that the two-stage tick pipeline settles before the count is read.

// File: rtl/disp_wdog_pkg.sv
package disp_wdog_pkg;
  typedef enum logic [1:0] {
    HWR_OFF  = 2'd0,
    HWR_RISE = 2'd1,
    HWR_FALL = 2'd2,
    HWR_RSVD = 2'd3
  } hwr_mode_e;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_RELOAD = 1;
  localparam int ADDR_COUNT  = 2;
  localparam int ADDR_FLAG   = 3;

  localparam int B_EN      = 0;
  localparam int B_DIS     = 1;
  localparam int B_FRC     = 2;
  localparam int B_STAT    = 3;
  localparam int B_SRC_LO  = 4;
  localparam int B_MODE_LO = 8;
endpackage

// File: rtl/disp_wdog_tick_sel.sv
module disp_wdog_tick_sel #(
  parameter int NUM_EVT = 4,
  parameter int SRC_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SRC_W-1:0]   src_i,
  input  logic               line_i,
  input  logic               frame_i,
  input  logic [2:0]         sync_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               tick_o
);
  localparam int NUM_SYNC = 3;
  localparam int NUM_SRC  = 2 + 2 * NUM_SYNC + NUM_EVT;

  logic [NUM_SYNC-1:0] sync_q;
  logic [NUM_SRC-1:0]  cand;
  logic                tick_q;

  assign cand[0] = line_i;
  assign cand[1] = frame_i;

  for (genvar s = 0; s < NUM_SYNC; s++) begin : g_sync
    assign cand[2 + 2 * s]     = sync_i[s] & ~sync_q[s];
    assign cand[2 + 2 * s + 1] = ~sync_i[s] & sync_q[s];
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    assign cand[2 + 2 * NUM_SYNC + e] = evt_i[e];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      tick_q <= 1'b0;
    end else begin
      sync_q <= sync_i;
      tick_q <= (int'(src_i) < NUM_SRC) ? cand[src_i] : 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R6
  reserved_src_chk: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (int'($past(src_i)) < NUM_SRC));
endmodule

// File: rtl/disp_wdog_rld_det.sv
module disp_wdog_rld_det
  import disp_wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  hwr_mode_e mode_i,
  input  logic      rld_i,
  output logic      hw_rld_o
);
  logic rld_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      rld_q <= rld_i;
      unique case (mode_i)
        HWR_RISE: pulse_q <= rld_i & ~rld_q;
        HWR_FALL: pulse_q <= ~rld_i & rld_q;
        default:  pulse_q <= 1'b0;
      endcase
    end
  end

  assign hw_rld_o = pulse_q;

  // R9
  hw_mode_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> ($past(mode_i) == HWR_RISE || $past(mode_i) == HWR_FALL));
endmodule

// File: rtl/disp_wdog_core.sv
module disp_wdog_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr_i,
  input  logic             dis_wr_i,
  input  logic             frc_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             hw_rld_i,
  input  logic [CNT_W-1:0] rld_val_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             load;
  logic             dec;

  assign load = frc_i | (en_wr_i & ~dis_wr_i) | (run_q & hw_rld_i);
  assign dec  = run_q & tick_i & ~load & (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (dis_wr_i)     run_q <= 1'b0;
      else if (en_wr_i) run_q <= 1'b1;

      if (load)     cnt_q <= rld_val_i;
      else if (dec) cnt_q <= cnt_q - 1'b1;

      if (dec && cnt_q == CNT_W'(1)) flag_q <= 1'b1;
      else if (clr_i)                flag_q <= 1'b0;
    end
  end

  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R3
  disable_stops_chk: assert property (@(posedge clk) disable iff (rst)
    dis_wr_i |=> !run_q);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !en_wr_i && !frc_i) |=> $stable(cnt_q));
  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !load) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
  // R12
  expiry_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> (cnt_q == '0));
endmodule

// File: rtl/disp_wdog.sv
module disp_wdog
  import disp_wdog_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  input  logic               line_i,
  input  logic               frame_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               te_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               rld_i,
  output logic               irq_o
);
  localparam int SRC_W = 4;

  logic [SRC_W-1:0] src_q;
  hwr_mode_e        mode_q;
  logic [CNT_W-1:0] rld_val_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  logic ctrl_wr, en_wr, dis_wr, frc, clr;
  logic tick, hw_rld, run, flag;
  logic [CNT_W-1:0] cnt;
  logic unused_wbits;

  assign ctrl_wr = wr_i && (int'(addr_i) == ADDR_CTRL);
  assign en_wr   = ctrl_wr && wdata_i[B_EN];
  assign dis_wr  = ctrl_wr && wdata_i[B_DIS];
  assign frc     = ctrl_wr && wdata_i[B_FRC];
  assign clr     = wr_i && (int'(addr_i) == ADDR_FLAG) && wdata_i[0];
  assign unused_wbits = ^{wdata_i[DATA_W-1:B_MODE_LO+2], wdata_i[B_STAT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      mode_q    <= HWR_OFF;
      rld_val_q <= '0;
    end else begin
      if (ctrl_wr) begin
        src_q  <= wdata_i[B_SRC_LO +: SRC_W];
        mode_q <= hwr_mode_e'(wdata_i[B_MODE_LO +: 2]);
      end
      if (wr_i && int'(addr_i) == ADDR_RELOAD)
        rld_val_q <= wdata_i[CNT_W-1:0];
    end
  end

  disp_wdog_tick_sel #(.NUM_EVT(NUM_EVT), .SRC_W(SRC_W)) tick_sel_i (
    .clk(clk), .rst(rst), .src_i(src_q), .line_i(line_i), .frame_i(frame_i),
    .sync_i({te_i, vsync_i, hsync_i}), .evt_i(evt_i), .tick_o(tick)
  );

  disp_wdog_rld_det rld_det_i (
    .clk(clk), .rst(rst), .mode_i(mode_q), .rld_i(rld_i), .hw_rld_o(hw_rld)
  );

  disp_wdog_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .en_wr_i(en_wr), .dis_wr_i(dis_wr), .frc_i(frc),
    .clr_i(clr), .tick_i(tick), .hw_rld_i(hw_rld), .rld_val_i(rld_val_q),
    .run_o(run), .cnt_o(cnt), .flag_o(flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) begin
        unique case (int'(addr_i))
          ADDR_CTRL:   rdata_q <= DATA_W'({mode_q, src_q, run, 3'b000});
          ADDR_RELOAD: rdata_q <= DATA_W'(rld_val_q);
          ADDR_COUNT:  rdata_q <= DATA_W'(cnt);
          default:     rdata_q <= DATA_W'(flag);
        endcase
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = flag;

  // R4
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rvalid_q);
endmodule

// File: tb/disp_wdog_tb_top.sv
module disp_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        line = 0, frame = 0, hs = 0, vs = 0, te = 0, rl = 0;
  logic [3:0]  evt = '0;
  logic        irq;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          src_v = 0, mode_v = 0;

  always #5 clk = ~clk;

  disp_wdog dut_i (
    .clk(clk), .rst(rst), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .line_i(line), .frame_i(frame),
    .hsync_i(hs), .vsync_i(vs), .te_i(te), .evt_i(evt), .rld_i(rl), .irq_o(irq)
  );

  // monitor: pops expected read values as the design returns them
  always @(negedge clk) begin
    if (rvalid) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(int a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic ctrl(int src, int mode, logic [2:0] bits);
    src_v = src; mode_v = mode;
    wreg(0, 32'(bits) | (32'(src) << 4) | (32'(mode) << 8));
  endtask

  task automatic expect_rd(int a, logic [31:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b1; addr = 2'(a);
    @(negedge clk);
    rd = 1'b0;
    idle(1);
  endtask

  task automatic chk_cnt(int e, string t);
    idle(3);
    expect_rd(2, 32'(e), t);
  endtask

  task automatic chk_bit(logic act, logic e, string t);
    tests++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  task automatic pulse_line();
    @(negedge clk); line = 1; @(negedge clk); line = 0;
  endtask

  task automatic pulse_evt(int k);
    @(negedge clk); evt[k] = 1; @(negedge clk); evt = '0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    expect_rd(0, 32'h0, "R1 ctrl");
    expect_rd(2, 32'h0, "R1 count");
    expect_rd(3, 32'h0, "R1 flag");
    chk_bit(irq, 1'b0, "R1 irq");

    wreg(1, 32'd5);
    ctrl(0, 0, 3'b000);
    expect_rd(0, 32'h0, "R2 enable write 0 no effect");
    ctrl(2, 0, 3'b001);
    expect_rd(0, 32'h28, "R4 status running src 2");
    chk_cnt(5, "R2 enable loads reload");

    // R7 hsync rise held long -> one tick
    @(negedge clk) hs = 1; idle(6); hs = 0;
    chk_cnt(4, "R7 single tick on held edge");
    ctrl(3, 0, 3'b000);
    @(negedge clk) hs = 1; idle(2); hs = 0;
    chk_cnt(3, "R5 hsync falling source");
    ctrl(0, 0, 3'b000);
    pulse_line(); pulse_line();
    chk_cnt(1, "R5 line pulses");
    expect_rd(3, 32'h0, "R12 no flag before zero");
    pulse_line();
    chk_cnt(0, "R12 reaches zero");
    expect_rd(3, 32'h1, "R12 flag set");
    chk_bit(irq, 1'b1, "R12 irq set");
    pulse_line();
    chk_cnt(0, "R12 stays at zero");
    wreg(3, 32'h1);
    expect_rd(3, 32'h0, "R12 flag cleared");
    chk_bit(irq, 1'b0, "R12 irq cleared");

    ctrl(0, 0, 3'b100);
    chk_cnt(5, "R8 force reload");
    expect_rd(0, 32'h08, "R8 force bit reads 0");

    for (int k = 0; k < 4; k++) begin
      ctrl(8 + k, 0, 3'b000);
      pulse_evt((k + 1) % 4);
      pulse_evt(k);
      chk_cnt(4 - k, $sformatf("R5 event %0d", k));
    end
    ctrl(1, 0, 3'b100);
    pulse_frame_blk: begin
      @(negedge clk); frame = 1; @(negedge clk); frame = 0;
    end
    pulse_line();
    chk_cnt(4, "R5 frame source, line ignored");
    ctrl(4, 0, 3'b000);
    @(negedge clk) vs = 1;
    chk_cnt(3, "R5 vsync rise");
    ctrl(5, 0, 3'b000);
    @(negedge clk) vs = 0;
    chk_cnt(2, "R5 vsync fall");
    ctrl(6, 0, 3'b100);
    @(negedge clk) te = 1;
    chk_cnt(4, "R5 te rise");
    ctrl(7, 0, 3'b000);
    @(negedge clk) te = 0;
    chk_cnt(3, "R5 te fall");

    for (int c = 12; c < 16; c++) begin
      ctrl(c, 0, 3'b000);
      pulse_line();
      @(negedge clk); frame = 1; evt = 4'hF; hs = 1; vs = 1; te = 1;
      @(negedge clk); frame = 0; evt = 4'h0; hs = 0; vs = 0; te = 0;
      chk_cnt(3, $sformatf("R6 reserved code %0d", c));
    end

    ctrl(0, 1, 3'b000);
    pulse_line();
    chk_cnt(2, "R9 line before hw reload");
    @(negedge clk) rl = 1;
    chk_cnt(5, "R9 rising reload");
    pulse_line();
    @(negedge clk) rl = 0;
    chk_cnt(4, "R9 falling ignored in mode 1");
    ctrl(0, 2, 3'b000);
    @(negedge clk) rl = 1;
    chk_cnt(4, "R9 rising ignored in mode 2");
    @(negedge clk) rl = 0;
    chk_cnt(5, "R9 falling reload");
    for (int m = 0; m < 4; m += 3) begin
      ctrl(0, m, 3'b000);
      pulse_line();
      @(negedge clk) rl = 1; idle(2); rl = 0;
      chk_cnt(4 - (m / 3), $sformatf("R9 mode %0d no reload", m));
    end

    ctrl(2, 1, 3'b000);
    @(negedge clk) hs = 1; rl = 1;
    chk_cnt(5, "R10 reload beats tick");
    @(negedge clk) hs = 0; rl = 0;
    ctrl(2, 1, 3'b000);
    expect_rd(0, 32'h128, "R3 disable write 0 no effect");
    @(negedge clk) hs = 1;
    chk_cnt(4, "R5 tick before disable");
    @(negedge clk) hs = 0;
    ctrl(2, 1, 3'b010);
    expect_rd(0, 32'h120, "R3 disabled status");
    @(negedge clk) hs = 1; rl = 1;
    chk_cnt(4, "R11 disabled ignores tick and reload");
    @(negedge clk) hs = 0; rl = 0;
    ctrl(2, 1, 3'b011);
    expect_rd(0, 32'h120, "R3 disable wins over enable");
    ctrl(2, 1, 3'b001);
    chk_cnt(5, "R2 re-enable reloads");

    idle(4);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4: got %0d pending reads expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule